// File: doc/BRIEF.md
# Booth Multiplier Cycle Sequencer

This block is the timing master of a multi-cycle radix-2 Booth multiplier for 13-bit operands. It has no data inputs. After reset it walks through a fixed schedule of 28 cycles and drives four strobes that tell the datapath what to do in each cycle:

- a preparation strobe, which loads the operands and clears the accumulator and the history bit;
- an arithmetic-slot strobe;
- a shift strobe;
- a completion flag.

The sequencer does not skip idle iterations. It grants an arithmetic slot on every iteration. The datapath decides, from the low multiplier bit and the history bit, whether the adder output is written or dropped.

The cycle index lives in a saturating counter. Every strobe is decoded from the registered count, so the strobes move only at rising clock edges. Reset is synchronous and active high. While reset is held the sequencer sits in cycle 0. Each edge without reset advances it by one cycle, until it parks in the final cycle.

Top module: `booth_seq`

## Requirements
- R1: A high `rst_i` sampled at a rising edge puts the sequencer in cycle 0 after that edge, and it stays in cycle 0 for as long as reset is sampled high.
- R2: In cycle 0, `prep_o` is 1 and the other three strobes are 0.
- R3: In each odd cycle from 1 to 25, `arith_o` is 1 and the other three strobes are 0.
- R4: In each even cycle from 2 to 26, `slide_o` is 1 and the other three strobes are 0.
- R5: In cycle 27, `done_o` is 1 and the other three strobes are 0. Cycle n is the state after n rising edges with reset low, counted from cycle 0.
- R6: Between leaving cycle 0 and reaching cycle 27, `arith_o` is high for exactly 13 cycles and `slide_o` is high for exactly 13 cycles. The strobes strictly alternate, starting with `arith_o`.
- R7: Once cycle 27 is reached, `done_o` stays 1 and no other strobe rises until reset is next sampled high.
- R8: Exactly one of the four strobes is 1 in every cycle.
- R9: The strobes change only at rising clock edges. Raising or lowering `rst_i` between edges leaves them unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high; returns the schedule to cycle 0 |
| prep_o | output | 1 | Load operands and clear accumulator and history bit |
| arith_o | output | 1 | Arithmetic slot; the datapath may write its adder result |
| slide_o | output | 1 | Arithmetic right shift of accumulator and multiplier |
| done_o | output | 1 | Product is complete and stable |

## Verification
The bench sweeps every cycle of the schedule, from held reset through several cycles of saturation. It compares the four strobes with a vector it computes from the cycle index, and it counts arithmetic and shift pulses per run.

The sweep is aimed at these boundaries:
- The seam between the last shift and completion. An off-by-one terminal count would either add a 14th iteration or raise `done_o` one cycle early.
- The saturation point. A counter that wraps would bring back `prep_o` or `arith_o` after completion.
- Reset asserted between edges in mid-run and after completion. An asynchronous or combinational reset path would change the strobes before the edge.
- A restart after reset. A counter that is not cleared would resume mid-schedule.

// File: rtl/booth_seq_pkg.sv
package booth_seq_pkg;

    // Which activity the current cycle belongs to.
    typedef enum logic [1:0] {
        PH_PREP  = 2'd0,
        PH_ARITH = 2'd1,
        PH_SLIDE = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    // Index of the final (parking) cycle for a given iteration count.
    function automatic int last_cycle(input int iters);
        return 2 * iters + 1;
    endfunction

endpackage

// File: rtl/booth_seq_counter.sv
module booth_seq_counter #(
    parameter int LAST = 27,
    parameter int CW   = 5
) (
    input  logic          clk_i,
    input  logic          rst_i,
    output logic [CW-1:0] cnt_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    localparam logic [CW-1:0] LastVal = CW'(LAST);

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LastVal) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/booth_seq_decode.sv
module booth_seq_decode
    import booth_seq_pkg::*;
#(
    parameter int LAST = 27,
    parameter int CW   = 5
) (
    input  logic [CW-1:0] cnt_i,
    output phase_e        phase_o,
    output logic          prep_o,
    output logic          arith_o,
    output logic          slide_o,
    output logic          done_o
);

    localparam logic [CW-1:0] LastVal = CW'(LAST);

    always_comb begin
        if (cnt_i == '0) begin
            phase_o = PH_PREP;
        end else if (cnt_i == LastVal) begin
            phase_o = PH_DONE;
        end else if (cnt_i[0]) begin
            phase_o = PH_ARITH;
        end else begin
            phase_o = PH_SLIDE;
        end
    end

    assign prep_o  = (phase_o == PH_PREP);
    assign arith_o = (phase_o == PH_ARITH);
    assign slide_o = (phase_o == PH_SLIDE);
    assign done_o  = (phase_o == PH_DONE);

endmodule

// File: rtl/booth_seq.sv
module booth_seq
    import booth_seq_pkg::*;
#(
    parameter int ITERS = 13
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic prep_o,
    output logic arith_o,
    output logic slide_o,
    output logic done_o
);

    localparam int LAST = last_cycle(ITERS);
    localparam int CW   = $clog2(LAST + 1);

    logic [CW-1:0] cnt_q;
    phase_e        phase;

    booth_seq_counter #(
        .LAST (LAST),
        .CW   (CW)
    ) u_counter (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .cnt_o (cnt_q)
    );

    booth_seq_decode #(
        .LAST (LAST),
        .CW   (CW)
    ) u_decode (
        .cnt_i   (cnt_q),
        .phase_o (phase),
        .prep_o  (prep_o),
        .arith_o (arith_o),
        .slide_o (slide_o),
        .done_o  (done_o)
    );

endmodule

// File: rtl/booth_seq_checker.sv
module booth_seq_checker #(
    parameter int ITERS = 13
) (
    input logic clk_i,
    input logic rst_i,
    input logic prep_o,
    input logic arith_o,
    input logic slide_o,
    input logic done_o
);

    localparam int CNTW = $clog2(ITERS + 2);

    // Arithmetic slots seen since the last reset; used instead of a long $past.
    logic [CNTW-1:0] arith_seen;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            arith_seen <= '0;
        end else if (arith_o) begin
            arith_seen <= arith_seen + 1'b1;
        end
    end

    p_reset_to_prep_r1: assert property (@(posedge clk_i)
        rst_i |=> prep_o);

    p_prep_then_arith_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        prep_o |=> arith_o);

    p_arith_then_slide_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        arith_o |=> slide_o);

    p_slide_then_next_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        slide_o |=> (arith_o || done_o));

    p_done_count_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !prep_o) |-> (arith_seen == CNTW'(ITERS)));

    p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> done_o);

    p_single_strobe_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot({prep_o, arith_o, slide_o, done_o}));

endmodule

bind booth_seq booth_seq_checker #(.ITERS(ITERS)) u_checker (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .prep_o  (prep_o),
    .arith_o (arith_o),
    .slide_o (slide_o),
    .done_o  (done_o)
);

// File: tb/booth_seq_test.sv
module booth_seq_test;

    localparam int ITERS = 13;
    localparam int LAST  = 2 * ITERS + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prep, arith, slide, done;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    booth_seq #(.ITERS(ITERS)) uut (
        .clk_i   (clk),
        .rst_i   (rst),
        .prep_o  (prep),
        .arith_o (arith),
        .slide_o (slide),
        .done_o  (done)
    );

    // Expected strobes as {prep, arith, slide, done} for cycle k.
    function automatic logic [3:0] expect_vec(input int k);
        if (k == 0)         return 4'b1000;
        else if (k >= LAST) return 4'b0001;
        else if (k % 2 == 1) return 4'b0100;
        else                return 4'b0010;
    endfunction

    function automatic string req_of(input int k);
        if (k == 0)          return "R2";
        else if (k > LAST)   return "R7";
        else if (k == LAST)  return "R5";
        else if (k % 2 == 1) return "R3";
        else                 return "R4";
    endfunction

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req, input int k);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: strobes=%b expected=%b", req, k, act, exp);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string req);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Walk from cycle 0 up to cycle upto, checking each cycle and counting pulses.
    task automatic sweep(input int upto, output int n_ar, output int n_sl, output int alt_err);
        logic prev_ar;
        n_ar = 0; n_sl = 0; alt_err = 0; prev_ar = 1'b0;
        for (int k = 0; k <= upto; k++) begin
            if (k > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            check({prep, arith, slide, done}, expect_vec(k), req_of(k), k);
            // R8: exactly one strobe each cycle
            n_tests++;
            if ($countones({prep, arith, slide, done}) != 1) begin
                n_fail++;
                $display("FAIL R8 cycle %0d: strobes=%b expected one-hot", k, {prep, arith, slide, done});
            end
            if (k > 0 && k < LAST) begin
                if (arith) begin
                    n_ar++;
                    if (prev_ar) alt_err++;
                end
                if (slide) begin
                    n_sl++;
                    if (!prev_ar) alt_err++;
                end
                prev_ar = arith;
            end
        end
    endtask

    initial begin
        int a, s, e;
        // R1: held reset parks in cycle 0
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({prep, arith, slide, done}, 4'b1000, "R1", 0);
        @(posedge clk);
        @(negedge clk);
        check({prep, arith, slide, done}, 4'b1000, "R1", 0);

        rst = 1'b0;
        sweep(LAST + 8, a, s, e);
        check_int(a, ITERS, "R6 arith count");
        check_int(s, ITERS, "R6 shift count");
        check_int(e, 0, "R6 alternation");

        // R9: reset raised between edges changes nothing before the edge
        rst = 1'b1;
        #2;
        check({prep, arith, slide, done}, 4'b0001, "R9", LAST);
        @(posedge clk);
        @(negedge clk);
        check({prep, arith, slide, done}, 4'b1000, "R1", 0);

        // Partial run, then reset mid-schedule
        rst = 1'b0;
        #2;
        check({prep, arith, slide, done}, 4'b1000, "R9", 0);
        sweep(12, a, s, e);
        rst = 1'b1;
        #2;
        check({prep, arith, slide, done}, expect_vec(12), "R9", 12);
        @(posedge clk);
        @(negedge clk);
        check({prep, arith, slide, done}, 4'b1000, "R1", 0);

        // Full restart after mid-run reset
        rst = 1'b0;
        sweep(LAST + 3, a, s, e);
        check_int(a, ITERS, "R6 arith count after restart");
        check_int(s, ITERS, "R6 shift count after restart");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule